// File: doc/BRIEF.md
# ADC Scan Sequencer with Chained Transfer Engines

This block runs a multi-channel ADC scan with no processor involvement between conversions. Two small transfer engines cooperate. The control engine fetches one channel-select byte from a table and issues it on the ADC command port, which starts a conversion. The ADC reports a finished conversion, and this sets a conversion-complete flag. The read engine then copies the 16-bit result into a result buffer. Each read hands a request back to the control engine, so the next command goes out at once.

Each engine keeps a byte address and an iteration counter that starts from the channel count. The control engine steps through the table one byte at a time. The read engine steps through the buffer two bytes at a time. When a pass over all channels ends, both addresses rewind to entry 0 and both counters reload, so the next pass writes over the same buffer. A start pulse launches a pass. With the repeat input held high, a new pass begins by itself as soon as the previous one ends. The read engine raises a pulse at the half-way point of a pass and another at the end of a pass.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset no command is issued and no buffer write occurs. Both interrupt pulses and the overrun flag are low, and the table and buffer addresses are 0.
- R2: A start pulse sampled while idle produces cmd_valid_o in the next cycle, with tbl_addr_o at 0. cmd_data_o is the table byte passed through unchanged: bit 7 is the differential flag, bits 4:0 are the input channel, and bits 6:5 are reserved.
- R3: Commands are taken from consecutive table bytes (address +1 each), in table order, and exactly NUM_CH commands make up one pass.
- R4: A result presented on res_valid_i is written in the following cycle. The write has buf_we_o high, the result on buf_wdata_o, and byte address 2*k on buf_addr_o for the k-th result of the pass.
- R5: After each buffer write except the last of a pass, the next command is issued in the following cycle.
- R6: When a result is pending and a command is pending in the same cycle, the buffer write happens first and the command follows one cycle later.
- R7: After NUM_CH writes, the table and buffer addresses return to 0 and the pass ends. No further command is issued until a new start, and the next pass again begins at table entry 0 and buffer address 0.
- R8: irq_done_o pulses for one cycle, in the cycle after the last write of a pass.
- R9: irq_half_o pulses for one cycle in the cycle after the write that leaves NUM_CH/2 iterations remaining. For NUM_CH=4 this is the second write.
- R10: A start pulse during an active pass is ignored: the command and write counts and addresses are unchanged. The pulse sets overrun_o, which stays high until reset.
- R11: If repeat_i is high when the last write of a pass occurs, the next pass starts without a start pulse. Its first command, taken from table entry 0, is issued in the cycle after that write.
- R12: Each result is written exactly once. The conversion-complete flag clears when the result is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Software start pulse for one pass |
| repeat_i | input | 1 | Restart automatically at the end of a pass |
| tbl_addr_o | output | TBL_AW | Channel table byte address |
| tbl_data_i | input | 8 | Channel table byte at tbl_addr_o |
| cmd_valid_o | output | 1 | ADC command strobe; starts a conversion |
| cmd_data_o | output | 8 | Channel select: bit 7 differential, bits 4:0 channel |
| res_valid_i | input | 1 | ADC conversion finished, result valid |
| res_data_i | input | 16 | ADC conversion result |
| buf_we_o | output | 1 | Result buffer write enable |
| buf_addr_o | output | BUF_AW | Result buffer byte address |
| buf_wdata_o | output | 16 | Result buffer write data |
| irq_half_o | output | 1 | Half-pass interrupt pulse |
| irq_done_o | output | 1 | End-of-pass interrupt pulse |
| overrun_o | output | 1 | Sticky flag for a start pulse that arrived while busy |

## Verification
The command strobe appears one cycle after the edge that samples a start or a link. A buffer write appears one cycle after the edge that captures a result. The next linked command comes one cycle after each write, and both interrupt pulses come one cycle after the write that triggers them. A monitor samples every output at the falling edge and records the cycle number of each command, write and pulse. The checks compare these recorded cycle numbers with the offsets above, not just the order of events. A behavioural ADC stub answers each command three cycles later with a value derived from the channel byte and a seed that changes per scenario. This lets the bench tell apart the results of back-to-back passes.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned SEL_W = 8;
  localparam int unsigned RES_W = 16;

  typedef struct packed {
    logic       diff;
    logic [1:0] rsvd;
    logic [4:0] chan;
  } chan_sel_t;
endpackage

// File: rtl/scan_xfer_engine.sv
module scan_xfer_engine #(
  parameter int unsigned ITER = 4,
  parameter int unsigned AW   = 8,
  parameter int unsigned STEP = 1,
  localparam int unsigned CW  = $clog2(ITER + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] citer_o,
  output logic          last_o
);
  localparam logic [AW-1:0] STEP_A   = AW'(STEP);
  localparam logic [AW-1:0] REWIND_A = AW'(ITER * STEP);
  localparam logic [CW-1:0] ITER_C   = CW'(ITER);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] citer_q;

  assign last_o  = (citer_q == CW'(1));
  assign addr_o  = addr_q;
  assign citer_o = citer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      citer_q <= ITER_C;
    end else if (go_i) begin
      if (last_o) begin
        addr_q  <= addr_q + STEP_A - REWIND_A;  // rewind to entry 0
        citer_q <= ITER_C;
      end else begin
        addr_q  <= addr_q + STEP_A;
        citer_q <= citer_q - CW'(1);
      end
    end
  end

  assert_citer_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (citer_q >= CW'(1)) && (citer_q <= ITER_C));

  assert_rewind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && last_o) |=> (addr_q == '0) && (citer_q == ITER_C));
endmodule

// File: rtl/scan_link_arb.sv
module scan_link_arb #(
  parameter int unsigned ITER    = 4,
  parameter int unsigned HALF_EN = 1,
  localparam int unsigned CW     = $clog2(ITER + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          repeat_i,
  input  logic          coco_i,
  input  logic          rd_last_i,
  input  logic [CW-1:0] rd_citer_i,
  output logic          rd_go_o,
  output logic          ctrl_go_o,
  output logic          irq_half_o,
  output logic          irq_done_o,
  output logic          overrun_o
);
  localparam int unsigned HALF      = ITER / 2;
  localparam bit          HALF_ON   = (HALF_EN != 0) && (HALF != 0);
  localparam logic [CW-1:0] HALF_TRIG = CW'(HALF + 1);

  logic active_q, ctrl_req_q, irq_half_q, irq_done_q, overrun_q;
  logic start_ok, link, pass_end;

  // read engine outranks control engine
  assign rd_go_o   = coco_i;
  assign ctrl_go_o = ctrl_req_q && !coco_i;

  assign start_ok = start_i && !active_q;
  assign pass_end = rd_go_o && rd_last_i;
  assign link     = rd_go_o && (active_q || start_ok) && (!rd_last_i || repeat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      ctrl_req_q <= 1'b0;
      irq_half_q <= 1'b0;
      irq_done_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      ctrl_req_q <= (ctrl_req_q && !ctrl_go_o) || start_ok || link;
      if (start_ok)                    active_q <= 1'b1;
      else if (pass_end && !repeat_i)  active_q <= 1'b0;
      irq_done_q <= pass_end;
      irq_half_q <= HALF_ON && rd_go_o && (rd_citer_i == HALF_TRIG);
      overrun_q  <= overrun_q || (start_i && active_q);
    end
  end

  assign irq_half_o = irq_half_q;
  assign irq_done_o = irq_done_q;
  assign overrun_o  = overrun_q;

  assert_overrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q |=> overrun_q);

  assert_irq_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_half_q |-> !irq_done_q);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned TBL_AW  = 6,
  parameter int unsigned BUF_AW  = 7,
  parameter int unsigned HALF_EN = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              repeat_i,
  output logic [TBL_AW-1:0] tbl_addr_o,
  input  logic [SEL_W-1:0]  tbl_data_i,
  output logic              cmd_valid_o,
  output logic [SEL_W-1:0]  cmd_data_o,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_data_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [RES_W-1:0]  buf_wdata_o,
  output logic              irq_half_o,
  output logic              irq_done_o,
  output logic              overrun_o
);
  localparam int unsigned CW = $clog2(NUM_CH + 1);

  logic             coco_q;
  logic [RES_W-1:0] res_q;
  logic             rd_go, ctrl_go, rd_last, ctrl_last;
  logic [CW-1:0]    rd_citer, ctrl_citer;
  chan_sel_t        sel;

  // conversion-complete flag and result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coco_q <= 1'b0;
      res_q  <= '0;
    end else if (res_valid_i) begin
      coco_q <= 1'b1;
      res_q  <= res_data_i;
    end else if (rd_go) begin
      coco_q <= 1'b0;
    end
  end

  scan_link_arb #(.ITER(NUM_CH), .HALF_EN(HALF_EN)) u_arb (
    .clk_i, .rst_ni, .start_i, .repeat_i,
    .coco_i    (coco_q),
    .rd_last_i (rd_last),
    .rd_citer_i(rd_citer),
    .rd_go_o   (rd_go),
    .ctrl_go_o (ctrl_go),
    .irq_half_o, .irq_done_o, .overrun_o
  );

  scan_xfer_engine #(.ITER(NUM_CH), .AW(TBL_AW), .STEP(1)) u_ctrl (
    .clk_i, .rst_ni,
    .go_i   (ctrl_go),
    .addr_o (tbl_addr_o),
    .citer_o(ctrl_citer),
    .last_o (ctrl_last)
  );

  scan_xfer_engine #(.ITER(NUM_CH), .AW(BUF_AW), .STEP(2)) u_read (
    .clk_i, .rst_ni,
    .go_i   (rd_go),
    .addr_o (buf_addr_o),
    .citer_o(rd_citer),
    .last_o (rd_last)
  );

  assign sel         = chan_sel_t'(tbl_data_i);
  assign cmd_valid_o = ctrl_go;
  assign cmd_data_o  = sel;
  assign buf_we_o    = rd_go;
  assign buf_wdata_o = res_q;

  assert_read_before_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coco_q |-> !cmd_valid_o);

  assert_single_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && !res_valid_i) |=> !buf_we_o);

  assert_link_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && !rd_last && !res_valid_i) |=> cmd_valid_o);

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> $past(buf_we_o && rd_last));

  assert_iter_lockstep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_citer == rd_citer) || (ctrl_citer + CW'(1) == rd_citer) ||
    (rd_citer + CW'(1) == ctrl_citer) ||
    ((ctrl_citer == CW'(NUM_CH)) && (rd_citer == CW'(1))));

  assert_last_cmd_last_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_go && ctrl_last) |-> rd_last);
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int NUM_CH = 4;
  localparam int TBL_AW = 6;
  localparam int BUF_AW = 7;
  localparam int LAT    = 3;
  localparam int LOGN   = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, repeat_i = 1'b0;
  logic [TBL_AW-1:0] tbl_addr;
  logic [7:0]  tbl_data, cmd_data;
  logic        cmd_valid, res_valid, buf_we, irq_half, irq_done, overrun;
  logic [15:0] res_data, buf_wdata;
  logic [BUF_AW-1:0] buf_addr;

  logic        stub_en = 1'b1, stub_vld = 1'b0, man_vld = 1'b0;
  logic [15:0] stub_data = '0, man_data = '0;
  logic [7:0]  seed = 8'h00, pend_cmd = '0;
  int          stub_cnt = 0;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int c_n = 0, w_n = 0, done_n = 0, half_n = 0, done_cyc = 0, half_cyc = 0;
  logic [7:0]  c_data [LOGN];
  int          c_cyc  [LOGN];
  logic [15:0] w_data [LOGN];
  logic [BUF_AW-1:0] w_addr [LOGN];
  int          w_cyc  [LOGN];

  always #5 clk = ~clk;

  function automatic logic [7:0] tbl_f(int i);
    int j = i % NUM_CH;
    return {j[0], 2'b00, 5'(2 + 3 * j)};
  endfunction

  function automatic logic [15:0] res_f(logic [7:0] c, logic [7:0] s);
    return {c ^ s, ~c};
  endfunction

  assign tbl_data  = tbl_f(int'(tbl_addr));
  assign res_valid = stub_vld | man_vld;
  assign res_data  = man_vld ? man_data : stub_data;

  adc_scan_seq #(.NUM_CH(NUM_CH), .TBL_AW(TBL_AW), .BUF_AW(BUF_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .repeat_i(repeat_i),
    .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data),
    .res_valid_i(res_valid), .res_data_i(res_data),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
    .irq_half_o(irq_half), .irq_done_o(irq_done), .overrun_o(overrun)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // monitor and ADC stub, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      stub_vld = 1'b0;
      if (stub_cnt > 0) begin
        stub_cnt--;
        if (stub_cnt == 0) begin
          stub_vld  = 1'b1;
          stub_data = res_f(pend_cmd, seed);
        end
      end
      if (cmd_valid) begin
        if (c_n < LOGN) begin c_data[c_n] = cmd_data; c_cyc[c_n] = cyc; end
        c_n++;
        if (stub_en) begin pend_cmd = cmd_data; stub_cnt = LAT; end
      end
      if (buf_we) begin
        if (w_n < LOGN) begin
          w_addr[w_n] = buf_addr; w_data[w_n] = buf_wdata; w_cyc[w_n] = cyc;
        end
        w_n++;
      end
      if (irq_done) begin done_n++; done_cyc = cyc; end
      if (irq_half) begin half_n++; half_cyc = cyc; end
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #2;
    rst_ni = 1'b0; start_i = 1'b0; repeat_i = 1'b0; man_vld = 1'b0; stub_en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    c_n = 0; w_n = 0; done_n = 0; half_n = 0; stub_cnt = 0;
    rst_ni = 1'b1;
  endtask

  task automatic pulse_start(output int at);
    @(posedge clk); #2;
    start_i = 1'b1; at = cyc;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_done(int n);
    int t = 0;
    while (done_n < n && t < 2000) begin @(posedge clk); t++; end
    chk(done_n >= n, "R8 pass end reached", done_n, n);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk); #1;
    chk(!cmd_valid && !buf_we, "R1 idle strobes", {cmd_valid, buf_we}, 0);
    chk(!irq_done && !irq_half && !overrun, "R1 flags low", {irq_done, irq_half, overrun}, 0);
    chk(tbl_addr == 0 && buf_addr == 0, "R1 addresses zero", {tbl_addr, buf_addr}, 0);
  endtask

  // single pass then back-to-back second pass
  task automatic t_scan_b2b();
    int at;
    bit ok;
    do_reset();
    seed = 8'h00;
    pulse_start(at);
    wait_done(1);
    chk(c_cyc[0] == at + 2, "R2 first command timing", c_cyc[0], at + 2);
    chk(c_data[0] == tbl_f(0), "R2 first command data", c_data[0], tbl_f(0));
    chk(c_n == NUM_CH, "R3 command count", c_n, NUM_CH);
    ok = 1;
    for (int k = 0; k < NUM_CH; k++) if (c_data[k] != tbl_f(k)) ok = 0;
    chk(ok, "R3 table order", c_data[NUM_CH-1], tbl_f(NUM_CH-1));
    for (int k = 0; k < NUM_CH; k++) begin
      chk(w_addr[k] == BUF_AW'(2 * k), "R4 write address", w_addr[k], 2 * k);
      chk(w_data[k] == res_f(tbl_f(k), 8'h00), "R4 write data", w_data[k], res_f(tbl_f(k), 8'h00));
    end
    for (int k = 0; k < NUM_CH - 1; k++)
      chk(c_cyc[k+1] == w_cyc[k] + 1, "R5 linked command timing", c_cyc[k+1], w_cyc[k] + 1);
    chk(done_n == 1 && done_cyc == w_cyc[NUM_CH-1] + 1, "R8 done pulse", done_cyc, w_cyc[NUM_CH-1] + 1);
    chk(half_n == 1 && half_cyc == w_cyc[NUM_CH/2-1] + 1, "R9 half pulse", half_cyc, w_cyc[NUM_CH/2-1] + 1);
    repeat (20) @(posedge clk);
    chk(c_n == NUM_CH && w_n == NUM_CH, "R7 pass ends", c_n, NUM_CH);
    chk(tbl_addr == 0 && buf_addr == 0, "R7 rewind", {tbl_addr, buf_addr}, 0);
    seed = 8'h5A;
    pulse_start(at);
    wait_done(2);
    for (int k = 0; k < NUM_CH; k++) begin
      chk(c_data[NUM_CH+k] == tbl_f(k), "R7 second pass command", c_data[NUM_CH+k], tbl_f(k));
      chk(w_addr[NUM_CH+k] == BUF_AW'(2 * k), "R7 second pass address", w_addr[NUM_CH+k], 2 * k);
      chk(w_data[NUM_CH+k] == res_f(tbl_f(k), 8'h5A), "R4 second pass data", w_data[NUM_CH+k], res_f(tbl_f(k), 8'h5A));
    end
    chk(half_n == 2, "R9 half pulse per pass", half_n, 2);
  endtask

  task automatic t_overrun();
    int at, t;
    do_reset();
    seed = 8'h33;
    pulse_start(at);
    t = 0;
    while (w_n < 1 && t < 200) begin @(posedge clk); t++; end
    pulse_start(at);
    wait_done(1);
    repeat (20) @(posedge clk);
    chk(c_n == NUM_CH && w_n == NUM_CH, "R10 busy start ignored", c_n, NUM_CH);
    chk(w_addr[NUM_CH-1] == BUF_AW'(2 * (NUM_CH - 1)), "R10 addresses unchanged", w_addr[NUM_CH-1], 2 * (NUM_CH - 1));
    chk(overrun, "R10 overrun set", overrun, 1);
    pulse_start(at);
    wait_done(2);
    chk(overrun, "R10 overrun sticky", overrun, 1);
    chk(c_data[NUM_CH] == tbl_f(0) && w_addr[NUM_CH] == 0, "R7 restart at entry 0", w_addr[NUM_CH], 0);
    do_reset();
    @(negedge clk); #1;
    chk(!overrun, "R1 overrun cleared by reset", overrun, 0);
  endtask

  task automatic t_repeat();
    int at, t;
    do_reset();
    seed = 8'hC1;
    @(posedge clk); #2 repeat_i = 1'b1;
    pulse_start(at);
    t = 0;
    while (w_n < NUM_CH + 1 && t < 500) begin @(posedge clk); t++; end
    #2 repeat_i = 1'b0;
    wait_done(2);
    repeat (20) @(posedge clk);
    chk(c_n == 2 * NUM_CH && w_n == 2 * NUM_CH, "R11 two passes from one start", w_n, 2 * NUM_CH);
    chk(c_data[NUM_CH] == tbl_f(0), "R11 restart at table 0", c_data[NUM_CH], tbl_f(0));
    chk(c_cyc[NUM_CH] == w_cyc[NUM_CH-1] + 1, "R11 restart timing", c_cyc[NUM_CH], w_cyc[NUM_CH-1] + 1);
    chk(w_addr[NUM_CH] == 0 && w_addr[2*NUM_CH-1] == BUF_AW'(2 * (NUM_CH - 1)), "R11 buffer wrap", w_addr[NUM_CH], 0);
    chk(w_data[2*NUM_CH-1] == res_f(tbl_f(NUM_CH-1), 8'hC1), "R11 data second pass", w_data[2*NUM_CH-1], res_f(tbl_f(NUM_CH-1), 8'hC1));
    chk(done_n == 2, "R8 one done per pass", done_n, 2);
  endtask

  task automatic t_priority();
    do_reset();
    stub_en = 1'b0;
    @(posedge clk); #2;
    start_i = 1'b1; man_vld = 1'b1; man_data = 16'hBEEF;
    @(posedge clk); #2;
    start_i = 1'b0; man_vld = 1'b0;
    @(negedge clk); #1;
    chk(buf_we && !cmd_valid, "R6 write before command", {buf_we, cmd_valid}, 2'b10);
    chk(buf_wdata == 16'hBEEF && buf_addr == 0, "R6 pending result stored", buf_wdata, 16'hBEEF);
    @(negedge clk); #1;
    chk(cmd_valid && !buf_we, "R6 command one cycle later", {buf_we, cmd_valid}, 2'b01);
    chk(cmd_data == tbl_f(0), "R6 command from entry 0", cmd_data, tbl_f(0));
    repeat (6) @(posedge clk);
    chk(w_n == 1, "R12 result written once", w_n, 1);
    chk(c_n == 1, "R12 no extra command", c_n, 1);
  endtask

  initial begin
    t_reset_state();
    t_scan_b2b();
    t_overrun();
    t_repeat();
    t_priority();
    do_reset();
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule